// File: doc/BRIEF.md
# Address Bus Parity Checker

The block watches the address and control lines that a bus master presents to a memory on each access, together with one parity bit that the master computes over those same lines. On every cycle where the access strobe is high, the block recomputes the parity over the address, the direction bit and the extra control bits. It then compares the result with the bit it received. A mismatch gives a one-cycle error pulse. The first failing access is also recorded: its direction goes into separate read and write failure flags, and its address goes into a register as a 64-bit-aligned offset from the memory base.

Once a failure has been recorded, the record is frozen. Later failures still pulse the error output, but they do not overwrite the flags or the offset. Recording starts again only after software has cleared both the status flags and the captured offset, each through its own clear strobe. The parity sense (even or odd) comes from a chip-wide select. A local override enable with its own sense bit can replace that chip-wide choice. The sense is sampled in the same cycle as the access it checks.

Top module: `addr_parity_guard`

## Requirements
- R1: On a clock edge where `acc_valid` is 1 and `acc_par` differs from the expected parity bit, `par_err` is 1 during the following cycle only. When parity matches, `par_err` stays 0.
- R2: When `acc_valid` is 0, no check is made. `par_err` is 0 in the next cycle, and the flags and offset are unchanged, whatever the other inputs are.
- R3: Parity covers the concatenation {`acc_addr`, `acc_write`, `acc_ctrl`}. With even sense (sense bit 0), the expected bit makes the count of ones over those lines plus `acc_par` even. With odd sense (sense bit 1), it makes that count odd. `glb_odd` gives the sense while `ovr_en` is 0.
- R4: While `ovr_en` is 1, `ovr_odd` gives the sense and `glb_odd` has no effect.
- R5: On a capture, `fail_offs` becomes (`acc_addr` − `BASE_ADDR`) modulo 2^ADDR_W, shifted right by 3. This is the index of the 64-bit word (BASE_ADDR defaults to 0x0800_0000).
- R6: On a capture, `rd_fail` is set if `acc_write` was 0 (read), and `wr_fail` is set if `acc_write` was 1 (write). The two flags are never both 1.
- R7: Capture happens only when no flag is set and no offset is being held. While locked, a failure still pulses `par_err` but leaves `rd_fail`, `wr_fail` and `fail_offs` unchanged.
- R8: `clr_status` clears both flags. `clr_addr` sets `fail_offs` to zero and releases the held offset. Capture resumes only after both clears have been applied. A capture in the same cycle as a clear takes precedence, because capture can only happen when nothing is held.
- R9: After reset, `par_err`, `rd_fail`, `wr_fail` and `fail_offs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | Access direction, 1 = write, 0 = read |
| acc_ctrl | input | CTRL_W | Further control lines covered by parity |
| acc_par | input | 1 | Parity bit sent by the master |
| glb_odd | input | 1 | Chip-wide parity sense, 1 = odd |
| ovr_en | input | 1 | Local override enable |
| ovr_odd | input | 1 | Local parity sense used while overriding |
| clr_status | input | 1 | Clears the read and write failure flags |
| clr_addr | input | 1 | Clears the captured offset |
| par_err | output | 1 | One-cycle failure pulse |
| rd_fail | output | 1 | A read access failed |
| wr_fail | output | 1 | A write access failed |
| fail_offs | output | ADDR_W-3 | Captured 64-bit word offset from base |

## Verification
The assertions assume that `acc_valid` is a one-cycle-per-access strobe and that the parity sense inputs are steady during each such cycle. They also assume that the clear strobes are ordinary synchronous pulses. The bench changes every input only on the falling edge, so each access presents one settled set of address, control and sense values at the rising edge. The bench mixes directed sequences for lock, partial clear and override with a long run of random accesses, senses and clears. All of these are compared each clock against a behavioural model.

// File: rtl/apg_pkg.sv
package apg_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } acc_dir_e;

    // expected parity bit for a given ones-parity and sense (1 = odd)
    function automatic logic expect_bit(input logic ones_par, input logic odd);
        return odd ? ~ones_par : ones_par;
    endfunction
endpackage

// File: rtl/apg_parity.sv
module apg_parity #(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              rx_par,
    input  logic              glb_odd,
    input  logic              ovr_en,
    input  logic              ovr_odd,
    output logic              mismatch
);
    localparam int COVER_W = ADDR_W + 1 + CTRL_W;

    logic [COVER_W-1:0] cover_bus;
    logic               ones_par;
    logic               sense_odd;

    always_comb begin
        cover_bus = {addr, write, ctrl};
        ones_par  = ^cover_bus;
        sense_odd = ovr_en ? ovr_odd : glb_odd;
        mismatch  = rx_par != apg_pkg::expect_bit(ones_par, sense_odd);
    end
endmodule

// File: rtl/apg_offset.sv
module apg_offset #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0800_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-4:0] offs
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel  = addr - BASE;
        offs = rel[ADDR_W-1:3];
    end
endmodule

// File: rtl/apg_capture.sv
module apg_capture #(
    parameter int OFFS_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  apg_pkg::acc_dir_e hit_dir,
    input  logic [OFFS_W-1:0] hit_offs,
    input  logic              clr_status,
    input  logic              clr_addr,
    output logic              err_pulse,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic [OFFS_W-1:0] offs
);
    typedef struct packed {
        logic              err;
        logic              rd;
        logic              wr;
        logic              held;
        logic [OFFS_W-1:0] offs;
    } cap_t;

    cap_t st_d, st_q;
    logic armed;

    always_comb begin
        st_d     = st_q;
        st_d.err = hit;
        armed    = !st_q.rd && !st_q.wr && !st_q.held;
        if (hit && armed) begin
            st_d.rd   = (hit_dir == apg_pkg::DIR_READ);
            st_d.wr   = (hit_dir == apg_pkg::DIR_WRITE);
            st_d.held = 1'b1;
            st_d.offs = hit_offs;
        end else begin
            if (clr_status) begin
                st_d.rd = 1'b0;
                st_d.wr = 1'b0;
            end
            if (clr_addr) begin
                st_d.held = 1'b0;
                st_d.offs = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_pulse = st_q.err;
    assign rd_flag   = st_q.rd;
    assign wr_flag   = st_q.wr;
    assign offs      = st_q.offs;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_flag && wr_flag)); // R6
    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !rd_flag && !wr_flag && !st_q.held) |=> $onehot({rd_flag, wr_flag})); // R6
    AST_LOCKED_OFFS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_flag || wr_flag) && !clr_addr) |=> $stable(offs)); // R7
    AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && (rd_flag || wr_flag)) |=> (!rd_flag && !wr_flag)); // R8
    AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> err_pulse); // R1
endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard #(
    parameter int          ADDR_W    = 32,
    parameter int          CTRL_W    = 4,
    parameter logic [31:0] BASE_ADDR = 32'h0800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [CTRL_W-1:0] acc_ctrl,
    input  logic              acc_par,
    input  logic              glb_odd,
    input  logic              ovr_en,
    input  logic              ovr_odd,
    input  logic              clr_status,
    input  logic              clr_addr,
    output logic              par_err,
    output logic              rd_fail,
    output logic              wr_fail,
    output logic [ADDR_W-4:0] fail_offs
);
    localparam int OFFS_W = ADDR_W - 3;

    logic              mismatch;
    logic [OFFS_W-1:0] cur_offs;
    logic              hit;
    apg_pkg::acc_dir_e dir;

    apg_parity #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) i_parity (
        .addr(acc_addr), .write(acc_write), .ctrl(acc_ctrl), .rx_par(acc_par),
        .glb_odd(glb_odd), .ovr_en(ovr_en), .ovr_odd(ovr_odd), .mismatch(mismatch)
    );

    apg_offset #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_offset (
        .addr(acc_addr), .offs(cur_offs)
    );

    always_comb begin
        hit = acc_valid && mismatch;
        dir = apg_pkg::acc_dir_e'(acc_write);
    end

    apg_capture #(.OFFS_W(OFFS_W)) i_capture (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_dir(dir), .hit_offs(cur_offs),
        .clr_status(clr_status), .clr_addr(clr_addr), .err_pulse(par_err),
        .rd_flag(rd_fail), .wr_flag(wr_fail), .offs(fail_offs)
    );

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !par_err); // R2
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !clr_status) |=> ($stable(rd_fail) && $stable(wr_fail))); // R2
endmodule

// File: tb/test_addr_parity_guard.sv
module test_addr_parity_guard;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam logic [31:0] BASE = 32'h0800_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_par = 0;
    logic glb_odd = 0, ovr_en = 0, ovr_odd = 0, clr_status = 0, clr_addr = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [CW-1:0] acc_ctrl = '0;
    logic par_err, rd_fail, wr_fail;
    logic [AW-4:0] fail_offs;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    addr_parity_guard #(.ADDR_W(AW), .CTRL_W(CW), .BASE_ADDR(BASE)) i_addr_parity_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_ctrl(acc_ctrl), .acc_par(acc_par),
        .glb_odd(glb_odd), .ovr_en(ovr_en), .ovr_odd(ovr_odd),
        .clr_status(clr_status), .clr_addr(clr_addr), .par_err(par_err),
        .rd_fail(rd_fail), .wr_fail(wr_fail), .fail_offs(fail_offs)
    );

    // behavioural reference model
    logic m_err = 0, m_rd = 0, m_wr = 0, m_held = 0;
    logic [AW-4:0] m_offs = '0;

    function automatic logic right_par(input logic [AW-1:0] a, input logic w,
                                       input logic [CW-1:0] c, input logic odd);
        int ones = $countones(a) + int'(w) + $countones(c);
        return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_err <= 0; m_rd <= 0; m_wr <= 0; m_held <= 0; m_offs <= '0;
        end else begin
            logic sense, bad;
            logic [AW-1:0] rel;
            sense = ovr_en ? ovr_odd : glb_odd;
            bad   = acc_valid && (acc_par != right_par(acc_addr, acc_write, acc_ctrl, sense));
            rel   = acc_addr - BASE;
            m_err <= bad;
            if (bad && !m_rd && !m_wr && !m_held) begin
                m_rd <= !acc_write; m_wr <= acc_write; m_held <= 1; m_offs <= rel[AW-1:3];
            end else begin
                if (clr_status) begin m_rd <= 0; m_wr <= 0; end
                if (clr_addr) begin m_held <= 0; m_offs <= '0; end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        chk("R1 par_err", par_err, m_err);
        chk("R6 rd_fail", rd_fail, m_rd);
        chk("R6 wr_fail", wr_fail, m_wr);
        chk("R5 fail_offs", fail_offs, m_offs);
    end

    task automatic access(input logic [AW-1:0] a, input logic w, input logic [CW-1:0] c,
                          input logic odd_for_par, input logic corrupt);
        acc_valid = 1; acc_addr = a; acc_write = w; acc_ctrl = c;
        acc_par = right_par(a, w, c, odd_for_par) ^ corrupt;
        @(negedge clk);
        acc_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset err", par_err, 0); chk("R9 reset rd", rd_fail, 0);
        chk("R9 reset wr", wr_fail, 0); chk("R9 reset offs", fail_offs, 0);
        // R1 good parity, even sense
        access(BASE + 32'h40, 0, 4'h3, 0, 0);
        chk("R1 good parity", par_err, 0);
        // R1/R5/R6 bad read
        access(BASE + 32'h88, 0, 4'h5, 0, 1);
        chk("R1 bad pulse", par_err, 1); chk("R6 read flag", rd_fail, 1);
        chk("R6 no write flag", wr_fail, 0); chk("R5 offset", fail_offs, 29'h11);
        @(negedge clk);
        chk("R1 single cycle", par_err, 0);
        // R7 locked: error pulses, record frozen
        access(BASE + 32'h1000, 1, 4'h1, 0, 1);
        chk("R7 pulse while locked", par_err, 1); chk("R7 rd kept", rd_fail, 1);
        chk("R7 wr unchanged", wr_fail, 0); chk("R7 offs kept", fail_offs, 29'h11);
        // R8 clear status only, still held
        clr_status = 1; @(negedge clk); clr_status = 0;
        chk("R8 status cleared", rd_fail, 0);
        access(BASE + 32'h2000, 1, 4'h2, 0, 1);
        chk("R8 held blocks wr", wr_fail, 0); chk("R8 held offs", fail_offs, 29'h11);
        clr_addr = 1; @(negedge clk); clr_addr = 0;
        chk("R8 offs cleared", fail_offs, 0);
        access(BASE + 32'h2008, 1, 4'h2, 0, 1);
        chk("R8 rearmed wr", wr_fail, 1); chk("R5 new offs", fail_offs, 29'h401);
        clr_status = 1; clr_addr = 1; @(negedge clk); clr_status = 0; clr_addr = 0;
        // R2 valid low with bad parity
        acc_addr = BASE; acc_par = ~right_par(BASE, 0, 0, 0); acc_ctrl = 0; acc_write = 0;
        @(negedge clk);
        chk("R2 idle no err", par_err, 0); chk("R2 idle no flag", rd_fail, 0);
        // R3 odd sense
        glb_odd = 1;
        access(BASE + 32'h8, 0, 4'h0, 1, 0);
        chk("R3 odd good", par_err, 0);
        access(BASE + 32'h8, 0, 4'h0, 0, 0);
        chk("R3 even bit under odd sense", par_err, 1);
        clr_status = 1; clr_addr = 1; @(negedge clk); clr_status = 0; clr_addr = 0;
        // R4 override even while global odd
        ovr_en = 1; ovr_odd = 0;
        access(BASE + 32'h18, 1, 4'h7, 0, 0);
        chk("R4 override even good", par_err, 0);
        access(BASE + 32'h18, 1, 4'h7, 1, 0);
        chk("R4 glb ignored", par_err, 1);
        ovr_en = 0; glb_odd = 0;
        clr_status = 1; clr_addr = 1; @(negedge clk); clr_status = 0; clr_addr = 0;
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            acc_valid  = ($urandom % 3) != 0;
            acc_addr   = BASE + ($urandom % 65536);
            acc_write  = $urandom;
            acc_ctrl   = $urandom;
            glb_odd    = $urandom;
            ovr_en     = $urandom;
            ovr_odd    = $urandom;
            acc_par    = right_par(acc_addr, acc_write, acc_ctrl, ovr_en ? ovr_odd : glb_odd)
                         ^ (($urandom % 4) == 0);
            clr_status = ($urandom % 8) == 0;
            clr_addr   = ($urandom % 8) == 0;
            @(negedge clk);
        end
        acc_valid = 0; clr_status = 0; clr_addr = 0;
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule